// File: doc/BRIEF.md
# Decimal Operand Sign and Shift Modifier

This block conditions one signed decimal operand before it goes onto a data bus or after it comes off one. The operand is a separate sign bit and a string of BCD digits, 19 by default. A one-digit modifier code picks the treatment. Codes 0 to 3 mark the operand as a source and change only its sign. Codes 4 to 9 mark it as a destination and shift it by a distance built from a one-digit shift field plus a coarse offset of 0, 10 or 20 places, so a single digit pair covers shifts of 0 to 29 places in either direction.

A separate bus-select digit of zero means the operand takes no part in the transfer. The block then presents a cleared value and flags it. If any input digit is not legal BCD, the block flags an error and forwards the operand untouched. The result is registered and appears one clock after the input is presented with its valid strobe. The registered result holds until the next valid input. The operand restriction for the first operand of an instruction (modifier 0 to 3 only) is left to the surrounding decoder.

Top module: `dec_operand_mod`

## Requirements
- R1: While reset is asserted and after it is released, outValid, outSign, outDigits, ignoreFlag, isDest and bcdError are all zero until the first valid input is captured.
- R2: A result appears on the outputs on the clock edge that samples inValid high, and outValid is high for exactly that following cycle. When inValid is low, outValid goes low and every other output keeps its value.
- R3: With modCode 0, 1, 2 or 3, the digits pass unchanged and isDest is 0. The sign becomes positive (0) for code 0, the inverse of the input sign for code 1, the input sign for code 2, and negative (1) for code 3.
- R4: With modCode 4 to 9, isDest is 1 and the digits shift by shiftDigit + 10·k places, where k is 0 for codes 4 and 5, 1 for codes 6 and 7, and 2 for codes 8 and 9. Even codes shift right, toward the least significant digit. Odd codes shift left. Digit i occupies bits [4i+3:4i], and digit 0 is the least significant.
- R5: Digits shifted out past either end are lost, and vacated positions fill with zero. A shift of NUM_DIGITS or more places gives all zero digits.
- R6: A destination result whose digits are all zero has a positive sign. Otherwise it keeps the input sign.
- R7: With busSel 0 and no illegal digit, ignoreFlag is 1, the digits are zero, the sign is positive and isDest is 0, whatever the modifier code.
- R8: If any operand digit, modCode, shiftDigit or busSel is 10 to 15, bcdError is 1, the input sign and digits pass unchanged, and ignoreFlag and isDest are 0. This takes precedence over R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Input operand and codes are presented this cycle |
| inSign | input | 1 | Operand sign, 1 = negative |
| inDigits | input | 4·NUM_DIGITS | Operand magnitude, BCD, digit 0 least significant |
| modCode | input | 4 | Modifier digit: 0–3 sign treatment, 4–9 shift |
| shiftDigit | input | 4 | Fine shift distance, 0–9 |
| busSel | input | 4 | Bus-select digit, 0 = operand ignored |
| outValid | output | 1 | Result registered from the previous cycle's input |
| outSign | output | 1 | Result sign |
| outDigits | output | 4·NUM_DIGITS | Result magnitude, BCD |
| ignoreFlag | output | 1 | Operand was marked as not used |
| isDest | output | 1 | Operand was treated as a destination (shifted) |
| bcdError | output | 1 | An input digit was outside 0–9 |

## Verification
Random operands with legal digits go through every modifier code and shift digit. This separates the four sign treatments from one another and right shifts from left shifts across all three coarse offsets. Directed cases cover the shift boundaries: zero places, 18 places (one digit left), and 19 and 29 places (all gone). These tell the discard and zero-fill behaviour apart from a wrap-around. Negative operands that shift to zero check that the sign is cleared. Cases with bus-select zero, and with a bad digit placed in each input field in turn, check the ignore path, the error pass-through and which of the two wins. Idle cycles between inputs check that the output register holds its value.

// File: rtl/decmod_pkg.sv
package decmod_pkg;
  localparam int DIGIT_W   = 4;
  localparam int MAX_SHIFT = 29;
  localparam int SHIFT_W   = $clog2(MAX_SHIFT + 1);

  typedef enum logic [1:0] {
    SGN_ABS  = 2'd0,
    SGN_INV  = 2'd1,
    SGN_KEEP = 2'd2,
    SGN_NEG  = 2'd3
  } signOp_e;

  typedef struct packed {
    logic               load;
    logic               passRaw;
    logic               zeroOut;
    logic               shiftEn;
    logic               shiftLeft;
    logic [SHIFT_W-1:0] shiftAmt;
    signOp_e            signOp;
  } ctrlStrobe_t;
endpackage

// File: rtl/decmod_ctrl.sv
module decmod_ctrl
  import decmod_pkg::*;
(
  input  logic        inValid,
  input  logic [3:0]  modCode,
  input  logic [3:0]  shiftDigit,
  input  logic [3:0]  busSel,
  input  logic        opBad,
  output ctrlStrobe_t ctl
);
  logic codeBad;
  logic [SHIFT_W-1:0] coarse;

  assign codeBad = (modCode > 4'd9) || (shiftDigit > 4'd9) || (busSel > 4'd9);

  always_comb begin
    case (modCode)
      4'd6, 4'd7: coarse = SHIFT_W'(10);
      4'd8, 4'd9: coarse = SHIFT_W'(20);
      default:    coarse = '0;
    endcase
  end

  always_comb begin
    ctl           = '0;
    ctl.signOp    = SGN_KEEP;
    ctl.load      = inValid;
    if (opBad || codeBad) begin
      ctl.passRaw = 1'b1;
    end else if (busSel == 4'd0) begin
      ctl.zeroOut = 1'b1;
    end else if (modCode >= 4'd4) begin
      ctl.shiftEn   = 1'b1;
      ctl.shiftLeft = modCode[0];
      ctl.shiftAmt  = SHIFT_W'(shiftDigit) + coarse;
    end else begin
      ctl.signOp    = signOp_e'(modCode[1:0]);
    end
  end
endmodule

// File: rtl/decmod_shift.sv
module decmod_shift
  import decmod_pkg::*;
#(
  parameter int NUM_DIGITS = 19
) (
  input  logic [NUM_DIGITS*DIGIT_W-1:0] din,
  input  logic [SHIFT_W-1:0]            amt,
  input  logic                          left,
  output logic [NUM_DIGITS*DIGIT_W-1:0] dout
);
  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_digit
    logic [DIGIT_W-1:0] pick;
    always_comb begin
      pick = '0;
      for (int k = 0; k < NUM_DIGITS; k++) begin
        if (left ? (k + int'(amt) == i) : (i + int'(amt) == k))
          pick = din[k*DIGIT_W +: DIGIT_W];
      end
    end
    assign dout[i*DIGIT_W +: DIGIT_W] = pick;
  end
endmodule

// File: rtl/decmod_dpath.sv
module decmod_dpath
  import decmod_pkg::*;
#(
  parameter int NUM_DIGITS = 19
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inValid,
  input  logic                          inSign,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] inDigits,
  input  ctrlStrobe_t                   ctl,
  output logic                          opBad,
  output logic                          outValid,
  output logic                          outSign,
  output logic [NUM_DIGITS*DIGIT_W-1:0] outDigits,
  output logic                          ignoreFlag,
  output logic                          isDest,
  output logic                          bcdError
);
  localparam int VW = NUM_DIGITS * DIGIT_W;

  logic [NUM_DIGITS-1:0] digBad;
  logic [VW-1:0]         shifted;
  logic [VW-1:0]         nxtDigits;
  logic                  nxtSign, srcSign, dstSign;

  for (genvar i = 0; i < NUM_DIGITS; i++) begin : g_chk
    assign digBad[i] = inDigits[i*DIGIT_W +: DIGIT_W] > 4'd9;
  end
  assign opBad = |digBad;

  decmod_shift #(.NUM_DIGITS(NUM_DIGITS)) u_shift (
    .din  (inDigits),
    .amt  (ctl.shiftAmt),
    .left (ctl.shiftLeft),
    .dout (shifted)
  );

  always_comb begin
    case (ctl.signOp)
      SGN_ABS: srcSign = 1'b0;
      SGN_INV: srcSign = ~inSign;
      SGN_NEG: srcSign = 1'b1;
      default: srcSign = inSign;
    endcase
  end

  assign dstSign = (shifted == '0) ? 1'b0 : inSign;

  always_comb begin
    if (ctl.passRaw) begin
      nxtDigits = inDigits;
      nxtSign   = inSign;
    end else if (ctl.zeroOut) begin
      nxtDigits = '0;
      nxtSign   = 1'b0;
    end else if (ctl.shiftEn) begin
      nxtDigits = shifted;
      nxtSign   = dstSign;
    end else begin
      nxtDigits = inDigits;
      nxtSign   = srcSign;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outValid   <= 1'b0;
      outSign    <= 1'b0;
      outDigits  <= '0;
      ignoreFlag <= 1'b0;
      isDest     <= 1'b0;
      bcdError   <= 1'b0;
    end else begin
      outValid <= ctl.load;
      if (ctl.load) begin
        outSign    <= nxtSign;
        outDigits  <= nxtDigits;
        ignoreFlag <= ctl.zeroOut;
        isDest     <= ctl.shiftEn;
        bcdError   <= ctl.passRaw;
      end
    end
  end

  a_r2_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid && $stable(outDigits) && $stable(outSign));

  a_r3_source_digits_kept: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && ctl.load |=> (!isDest && !ignoreFlag && !bcdError) ->
      (outDigits == $past(inDigits)));

  a_r3_abs_is_positive: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && !ctl.passRaw && !ctl.zeroOut && !ctl.shiftEn && ctl.signOp == SGN_ABS
      |=> !outSign);

  a_r5_far_shift_zero: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && ctl.shiftEn && !ctl.passRaw && int'(ctl.shiftAmt) >= NUM_DIGITS
      |=> outDigits == '0);

  a_r6_zero_dest_positive: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && isDest && outDigits == '0 |-> !outSign);

  a_r7_ignored_cleared: assert property (@(posedge clk) disable iff (!rst_n)
    outValid && ignoreFlag |-> outDigits == '0 && !outSign && !isDest && !bcdError);

  a_r8_error_passes_raw: assert property (@(posedge clk) disable iff (!rst_n)
    inValid && opBad |=> bcdError && outDigits == $past(inDigits) &&
      outSign == $past(inSign) && !ignoreFlag && !isDest);
endmodule

// File: rtl/dec_operand_mod.sv
module dec_operand_mod
  import decmod_pkg::*;
#(
  parameter int NUM_DIGITS = 19
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          inValid,
  input  logic                          inSign,
  input  logic [NUM_DIGITS*DIGIT_W-1:0] inDigits,
  input  logic [3:0]                    modCode,
  input  logic [3:0]                    shiftDigit,
  input  logic [3:0]                    busSel,
  output logic                          outValid,
  output logic                          outSign,
  output logic [NUM_DIGITS*DIGIT_W-1:0] outDigits,
  output logic                          ignoreFlag,
  output logic                          isDest,
  output logic                          bcdError
);
  ctrlStrobe_t ctl;
  logic        opBad;

  decmod_ctrl u_ctrl (
    .inValid    (inValid),
    .modCode    (modCode),
    .shiftDigit (shiftDigit),
    .busSel     (busSel),
    .opBad      (opBad),
    .ctl        (ctl)
  );

  decmod_dpath #(.NUM_DIGITS(NUM_DIGITS)) u_dpath (
    .clk        (clk),
    .rst_n      (rst_n),
    .inValid    (inValid),
    .inSign     (inSign),
    .inDigits   (inDigits),
    .ctl        (ctl),
    .opBad      (opBad),
    .outValid   (outValid),
    .outSign    (outSign),
    .outDigits  (outDigits),
    .ignoreFlag (ignoreFlag),
    .isDest     (isDest),
    .bcdError   (bcdError)
  );
endmodule

// File: tb/sim_dec_operand_mod.sv
`timescale 1ns/1ps
module sim_dec_operand_mod;
  localparam int ND = 19;
  localparam int VW = ND * 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic inValid = 1'b0;
  logic inSign = 1'b0;
  logic [VW-1:0] inDigits = '0;
  logic [3:0] modCode = '0, shiftDigit = '0, busSel = '0;
  logic outValid, outSign, ignoreFlag, isDest, bcdError;
  logic [VW-1:0] outDigits;

  int nChecks = 0;
  int nFails  = 0;
  bit done    = 1'b0;

  always #10 clk = ~clk;

  dec_operand_mod #(.NUM_DIGITS(ND)) u0 (
    .clk(clk), .rst_n(rst_n), .inValid(inValid), .inSign(inSign),
    .inDigits(inDigits), .modCode(modCode), .shiftDigit(shiftDigit),
    .busSel(busSel), .outValid(outValid), .outSign(outSign),
    .outDigits(outDigits), .ignoreFlag(ignoreFlag), .isDest(isDest),
    .bcdError(bcdError)
  );

  task automatic checkVal(input string tag, input string what,
                          input logic [VW-1:0] act, input logic [VW-1:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic void refModel(
    input logic s, input logic [VW-1:0] d, input logic [3:0] m, sh, b,
    output logic eS, output logic [VW-1:0] eD,
    output logic eIgn, output logic eDst, output logic eErr);
    bit bad = (m > 9) || (sh > 9) || (b > 9);
    for (int k = 0; k < ND; k++) if (d[k*4 +: 4] > 9) bad = 1'b1;
    eIgn = 1'b0; eDst = 1'b0; eErr = 1'b0;
    if (bad) begin
      eErr = 1'b1; eS = s; eD = d;
    end else if (b == 0) begin
      eIgn = 1'b1; eS = 1'b0; eD = '0;
    end else if (m < 4) begin
      eD = d;
      case (m)
        4'd0: eS = 1'b0;
        4'd1: eS = ~s;
        4'd2: eS = s;
        default: eS = 1'b1;
      endcase
    end else begin
      int amt = int'(sh) + 10 * ((int'(m) - 4) / 2);
      eDst = 1'b1;
      eD = '0;
      for (int k = 0; k < ND; k++) begin
        if (m[0]) begin
          if (k >= amt) eD[k*4 +: 4] = d[(k-amt)*4 +: 4];
        end else begin
          if (k + amt < ND) eD[k*4 +: 4] = d[(k+amt)*4 +: 4];
        end
      end
      eS = (eD == '0) ? 1'b0 : s;
    end
  endfunction

  task automatic applyOne(input string tag, input logic s, input logic [VW-1:0] d,
                          input logic [3:0] m, input logic [3:0] sh, input logic [3:0] b);
    logic eS, eIgn, eDst, eErr;
    logic [VW-1:0] eD;
    refModel(s, d, m, sh, b, eS, eD, eIgn, eDst, eErr);
    @(negedge clk);
    inValid = 1'b1; inSign = s; inDigits = d;
    modCode = m; shiftDigit = sh; busSel = b;
    @(negedge clk);
    inValid = 1'b0;
    checkVal(tag, "outValid", VW'(outValid), VW'(1));
    checkVal(tag, "outDigits", outDigits, eD);
    checkVal(tag, "outSign", VW'(outSign), VW'(eS));
    checkVal(tag, "ignoreFlag", VW'(ignoreFlag), VW'(eIgn));
    checkVal(tag, "isDest", VW'(isDest), VW'(eDst));
    checkVal(tag, "bcdError", VW'(bcdError), VW'(eErr));
  endtask

  function automatic logic [VW-1:0] randDigits();
    logic [VW-1:0] v;
    for (int k = 0; k < ND; k++) v[k*4 +: 4] = 4'($urandom_range(0, 9));
    return v;
  endfunction

  function automatic string tagFor(input logic [VW-1:0] d, input logic [3:0] m, sh, b);
    bit bad = (m > 9) || (sh > 9) || (b > 9);
    for (int k = 0; k < ND; k++) if (d[k*4 +: 4] > 9) bad = 1'b1;
    if (bad) return "R8";
    if (b == 0) return "R7";
    if (m < 4) return "R3";
    return "R4";
  endfunction

  initial begin
    #(20 * 200000);
    if (!done) begin
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
      $finish;
    end
  end

  initial begin
    logic [VW-1:0] pat;
    logic [VW-1:0] heldD;
    logic heldS;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    // R1: reset state
    checkVal("R1", "outValid", VW'(outValid), '0);
    checkVal("R1", "outDigits", outDigits, '0);
    checkVal("R1", "flags", VW'({outSign, ignoreFlag, isDest, bcdError}), '0);
    rst_n = 1'b1;
    @(negedge clk);
    checkVal("R1", "outValid after release", VW'(outValid), '0);
    checkVal("R1", "outDigits after release", outDigits, '0);

    pat = '0;
    for (int k = 0; k < ND; k++) pat[k*4 +: 4] = 4'((k % 9) + 1);

    // R3 directed sign treatments
    applyOne("R3", 1'b1, pat, 4'd0, 4'd0, 4'd3);
    applyOne("R3", 1'b1, pat, 4'd1, 4'd0, 4'd3);
    applyOne("R3", 1'b0, pat, 4'd2, 4'd0, 4'd3);
    applyOne("R3", 1'b0, pat, 4'd3, 4'd0, 4'd3);
    // R4 shift distances and directions
    applyOne("R4", 1'b0, pat, 4'd4, 4'd0, 4'd1);
    applyOne("R4", 1'b1, pat, 4'd4, 4'd3, 4'd1);
    applyOne("R4", 1'b0, pat, 4'd5, 4'd3, 4'd1);
    applyOne("R4", 1'b0, pat, 4'd6, 4'd2, 4'd1);
    applyOne("R4", 1'b0, pat, 4'd7, 4'd2, 4'd1);
    // R5 boundaries: 18 places keeps one digit, 19 and 29 clear all
    applyOne("R5", 1'b0, pat, 4'd6, 4'd8, 4'd1);
    applyOne("R5", 1'b0, pat, 4'd7, 4'd8, 4'd1);
    applyOne("R5", 1'b0, pat, 4'd7, 4'd9, 4'd1);
    applyOne("R5", 1'b0, pat, 4'd8, 4'd9, 4'd1);
    applyOne("R5", 1'b0, pat, 4'd9, 4'd9, 4'd1);
    // R6 negative shifted to zero becomes positive
    applyOne("R6", 1'b1, pat, 4'd9, 4'd9, 4'd2);
    applyOne("R6", 1'b1, VW'(64'h7), 4'd4, 4'd1, 4'd2);
    applyOne("R6", 1'b1, VW'(64'h7), 4'd4, 4'd0, 4'd2);
    // R7 ignored operand
    applyOne("R7", 1'b1, pat, 4'd5, 4'd4, 4'd0);
    applyOne("R7", 1'b1, pat, 4'd1, 4'd0, 4'd0);
    // R8 illegal digit in each field, and precedence over bus zero
    applyOne("R8", 1'b1, pat | VW'(64'hA0), 4'd5, 4'd1, 4'd2);
    applyOne("R8", 1'b0, pat, 4'd12, 4'd1, 4'd2);
    applyOne("R8", 1'b1, pat, 4'd5, 4'd11, 4'd2);
    applyOne("R8", 1'b1, pat, 4'd5, 4'd1, 4'd15);
    applyOne("R8", 1'b1, pat | (VW'(64'hF) << (4*(ND-1))), 4'd2, 4'd0, 4'd0);

    // R2: output holds while idle
    heldD = outDigits; heldS = outSign;
    repeat (2) @(negedge clk);
    checkVal("R2", "outValid idle", VW'(outValid), '0);
    checkVal("R2", "outDigits held", outDigits, heldD);
    checkVal("R2", "outSign held", VW'(outSign), VW'(heldS));

    // random mix
    for (int n = 0; n < 400; n++) begin
      logic [VW-1:0] d = randDigits();
      logic [3:0] m  = 4'($urandom_range(0, 9));
      logic [3:0] sh = 4'($urandom_range(0, 9));
      logic [3:0] b  = ($urandom_range(0, 7) == 0) ? 4'd0 : 4'($urandom_range(1, 9));
      logic s = 1'($urandom_range(0, 1));
      if ($urandom_range(0, 15) == 0) begin
        int p = $urandom_range(0, ND - 1);
        d[p*4 +: 4] = 4'($urandom_range(10, 15));
      end
      applyOne(tagFor(d, m, sh, b), s, d, m, sh, b);
    end

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end
endmodule